// File: doc/BRIEF.md
# Eight-Channel Reloadable Down-Counter Bank

The block is a memory-mapped bank of eight independent 32-bit down-counters. Software reaches it over a plain word bus: a byte offset, a write strobe, write data, and read data that follows the offset in the same cycle. Each channel has four words: a live count, a reload value and two match words. The match words are only stored and read back. A single shared control word gives each channel four bits: run, slow-tick select, interrupt enable and waveform enable.

Each running channel counts down by one on every cycle in which its chosen tick input is high. It can use a slow external tick or a fast bus-derived tick. When the count is already zero, the next tick copies the reload value into the count and fires that channel's interrupt line for one clock, provided its interrupt enable is set. Control writes act on changes only. Clearing a run bit that was set stops the channel and copies the reload value into the count.

The word map is split around the control words. Channels 0 to 2 use 16-byte slots 0 to 2. The control word is at 0x30 and a spare control word is at 0x34. Channels 3 to 7 use slots 4 to 8, so their channel number is the slot number minus one.

Top module: `timer_bank`

## Requirements
- R1: After reset every count, reload, match and control word reads as zero, all interrupt lines are low and `cfg_err` is low.
- R2: Channel n uses slot s = n for n < 3 and s = n + 1 otherwise, at byte offset 16*s. Within a slot, word +0x0 is the count, +0x4 the reload, +0x8 match A and +0xC match B. Reload and match words read back what was written.
- R3: Offsets 0x38 and 0x3C, offsets of 0x90 and above, and any offset with a nonzero low two bits read as zero, and writes to them change no register.
- R4: Control bit 4n+0 is channel n's run bit, 4n+1 its slow-tick select, 4n+2 its interrupt enable and 4n+3 its waveform enable. With slow-tick select at 1 the channel counts on `ext_tick` only; with it at 0 the channel counts on `bus_tick` only.
- R5: A running channel with a nonzero count decrements by exactly one on each cycle its selected tick is high. A channel that is not running keeps its count.
- R6: A selected tick that arrives while the count is zero loads the reload value. The channel's `irq` bit is then high for the following clock if, and only if, its interrupt enable was 1.
- R7: A control write that clears a run bit which was 1 loads that channel's count from its reload value. A control write that leaves a run bit at 0 does not touch the count.
- R8: A write to a count word sets the count only while that channel is running; otherwise it is ignored.
- R9: A reload write stores the value without changing the live count. The new value is the one loaded at the next wrap or stop.
- R10: Waveform-enable bits of channels 4 to 7 are stored. For channels 0 to 3 the bit is not stored, reads back as 0, and writing it as 1 makes `cfg_err` high for one clock.
- R11: The spare control word at 0x34 stores and reads back any value with no other effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_tick | input | 1 | Slow external tick enable |
| bus_tick | input | 1 | Fast bus-derived tick enable |
| addr | input | 8 | Byte offset of the accessed word |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| irq | output | 8 | One-clock interrupt pulse per channel |
| cfg_err | output | 1 | One-clock pulse on an illegal waveform-enable request |

## Verification
The bench builds the block with its default values: eight channels, three channels below the control words, and waveform support from channel 4 upward. With these values both address windows, the gap slot and the legal/illegal waveform boundary all fall inside one small map. The bench drives both tick inputs itself, so the selected and unselected tick cases, and both together, come up every few cycles. Reload values of 0 to 5 make a wrap, with or without an interrupt, reachable many times in each random round.

// File: rtl/ttb_pkg.sv
package ttb_pkg;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned CTL_W  = 4;
    localparam int unsigned CB_RUN  = 0;
    localparam int unsigned CB_SLOW = 1;
    localparam int unsigned CB_IRQ  = 2;
    localparam int unsigned CB_WAVE = 3;

    typedef enum logic [1:0] {
        F_COUNT   = 2'd0,
        F_RELOAD  = 2'd1,
        F_MATCH_A = 2'd2,
        F_MATCH_B = 2'd3
    } tmr_field_e;

    typedef struct packed {
        logic [DATA_W-1:0] count;
        logic [DATA_W-1:0] reload;
        logic [DATA_W-1:0] match_a;
        logic [DATA_W-1:0] match_b;
        logic              irq;
    } chan_state_t;

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] ctrl2;
        logic              err;
    } bank_state_t;
endpackage

// File: rtl/ttb_addr_dec.sv
module ttb_addr_dec
    import ttb_pkg::*;
#(
    parameter int unsigned NUM_TMR = 8,
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned LOW_WIN = 3
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [NUM_TMR-1:0] tmr_sel,
    output tmr_field_e         field,
    output logic               hit_ctrl,
    output logic               hit_ctrl2
);
    localparam int unsigned SLOT_W = ADDR_W - 4;

    logic [SLOT_W-1:0] slot;
    logic [1:0]        word;
    logic              aligned;

    assign slot    = addr[ADDR_W-1:4];
    assign word    = addr[3:2];
    assign aligned = (addr[1:0] == 2'b00);
    assign field   = tmr_field_e'(word);

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_sel
        localparam int unsigned SLOT_I = (i < LOW_WIN) ? i : i + 1;
        assign tmr_sel[i] = aligned && (slot == SLOT_W'(SLOT_I));
    end

    assign hit_ctrl  = aligned && (slot == SLOT_W'(LOW_WIN)) && (word == 2'd0);
    assign hit_ctrl2 = aligned && (slot == SLOT_W'(LOW_WIN)) && (word == 2'd1);
endmodule

// File: rtl/ttb_channel.sv
module ttb_channel
    import ttb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              slow_sel,
    input  logic              irq_en,
    input  logic              ext_tick,
    input  logic              bus_tick,
    input  logic              stop_ev,
    input  logic              wr_count,
    input  logic              wr_reload,
    input  logic              wr_match_a,
    input  logic              wr_match_b,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] count,
    output logic [DATA_W-1:0] reload,
    output logic [DATA_W-1:0] match_a,
    output logic [DATA_W-1:0] match_b,
    output logic              irq
);
    chan_state_t cur_q, nxt_d;
    logic        tick;
    logic        wrap;

    always_comb begin
        nxt_d = cur_q;
        wrap  = 1'b0;
        tick  = slow_sel ? ext_tick : bus_tick;
        if (run && tick) begin
            if (cur_q.count == '0) begin
                nxt_d.count = cur_q.reload;
                wrap        = 1'b1;
            end else begin
                nxt_d.count = cur_q.count - 1'b1;
            end
        end
        // a software count write wins over the tick
        if (wr_count && run) begin
            nxt_d.count = wdata;
        end
        // stopping a running channel restores the reload value
        if (stop_ev) begin
            nxt_d.count = cur_q.reload;
        end
        if (wr_reload) begin
            nxt_d.reload = wdata;
        end
        if (wr_match_a) begin
            nxt_d.match_a = wdata;
        end
        if (wr_match_b) begin
            nxt_d.match_b = wdata;
        end
        nxt_d.irq = wrap && irq_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign count   = cur_q.count;
    assign reload  = cur_q.reload;
    assign match_a = cur_q.match_a;
    assign match_b = cur_q.match_b;
    assign irq     = cur_q.irq;

    p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !stop_ev) |=> $stable(cur_q.count));

    p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && (cur_q.count != '0) && !wr_count && !stop_ev)
        |=> (cur_q.count == $past(cur_q.count) - 1'b1));

    p_wrap_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && (cur_q.count == '0) && !wr_count && !stop_ev)
        |=> (cur_q.count == $past(cur_q.reload)));

    p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.irq |-> $past(irq_en));

    p_stop_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (cur_q.count == $past(cur_q.reload)));
endmodule

// File: rtl/timer_bank.sv
module timer_bank
    import ttb_pkg::*;
#(
    parameter int unsigned NUM_TMR    = 8,
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned LOW_WIN    = 3,
    parameter int unsigned WAVE_FIRST = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ext_tick,
    input  logic               bus_tick,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [DATA_W-1:0]  rd_data,
    output logic [NUM_TMR-1:0] irq,
    output logic               cfg_err
);
    localparam int unsigned CTRL_BITS = NUM_TMR * CTL_W;

    function automatic logic [DATA_W-1:0] wave_ban_bits();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_TMR; i++) begin
            if (i < WAVE_FIRST) begin
                m[i*CTL_W + CB_WAVE] = 1'b1;
            end
        end
        return m;
    endfunction

    localparam logic [DATA_W-1:0] WAVE_BAN = wave_ban_bits();

    bank_state_t        cur_q, nxt_d;
    logic [NUM_TMR-1:0] tmr_sel;
    tmr_field_e         field;
    logic               hit_ctrl, hit_ctrl2;
    logic               ctl_wr;
    logic [NUM_TMR-1:0] stop_ev;
    logic [DATA_W-1:0]  ch_count   [NUM_TMR];
    logic [DATA_W-1:0]  ch_reload  [NUM_TMR];
    logic [DATA_W-1:0]  ch_match_a [NUM_TMR];
    logic [DATA_W-1:0]  ch_match_b [NUM_TMR];

    ttb_addr_dec #(
        .NUM_TMR (NUM_TMR),
        .ADDR_W  (ADDR_W),
        .LOW_WIN (LOW_WIN)
    ) i_dec (
        .addr      (addr),
        .tmr_sel   (tmr_sel),
        .field     (field),
        .hit_ctrl  (hit_ctrl),
        .hit_ctrl2 (hit_ctrl2)
    );

    assign ctl_wr = wr_en && hit_ctrl;

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.err = 1'b0;
        if (ctl_wr) begin
            nxt_d.ctrl = wr_data & ~WAVE_BAN;
            nxt_d.err  = |(wr_data & WAVE_BAN);
        end
        if (wr_en && hit_ctrl2) begin
            nxt_d.ctrl2 = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_ch
        localparam int unsigned B = i * CTL_W;

        assign stop_ev[i] = ctl_wr && cur_q.ctrl[B + CB_RUN] && !wr_data[B + CB_RUN];

        ttb_channel i_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .run        (cur_q.ctrl[B + CB_RUN]),
            .slow_sel   (cur_q.ctrl[B + CB_SLOW]),
            .irq_en     (cur_q.ctrl[B + CB_IRQ]),
            .ext_tick   (ext_tick),
            .bus_tick   (bus_tick),
            .stop_ev    (stop_ev[i]),
            .wr_count   (wr_en && tmr_sel[i] && (field == F_COUNT)),
            .wr_reload  (wr_en && tmr_sel[i] && (field == F_RELOAD)),
            .wr_match_a (wr_en && tmr_sel[i] && (field == F_MATCH_A)),
            .wr_match_b (wr_en && tmr_sel[i] && (field == F_MATCH_B)),
            .wdata      (wr_data),
            .count      (ch_count[i]),
            .reload     (ch_reload[i]),
            .match_a    (ch_match_a[i]),
            .match_b    (ch_match_b[i]),
            .irq        (irq[i])
        );
    end

    always_comb begin
        rd_data = '0;
        if (hit_ctrl) begin
            rd_data = cur_q.ctrl;
        end
        if (hit_ctrl2) begin
            rd_data = cur_q.ctrl2;
        end
        for (int i = 0; i < NUM_TMR; i++) begin
            if (tmr_sel[i]) begin
                case (field)
                    F_COUNT:   rd_data = ch_count[i];
                    F_RELOAD:  rd_data = ch_reload[i];
                    F_MATCH_A: rd_data = ch_match_a[i];
                    default:   rd_data = ch_match_b[i];
                endcase
            end
        end
    end

    assign cfg_err = cur_q.err;

    initial begin
        if (CTRL_BITS > DATA_W) begin
            $error("control word too narrow for channel count");
        end
    end

    p_ctrl_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr |=> $stable(cur_q.ctrl));

    p_err_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.err |-> $past(ctl_wr));

    p_spare_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && hit_ctrl2) |=> $stable(cur_q.ctrl2));
endmodule

// File: tb/test_timer_bank.sv
`timescale 1ns/1ps
module test_timer_bank;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ext_tick, bus_tick;
    logic [7:0]  addr;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic [7:0]  irq;
    logic        cfg_err;

    int errs   = 0;
    int checks = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    timer_bank i_timer_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_tick (ext_tick),
        .bus_tick (bus_tick),
        .addr     (addr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .irq      (irq),
        .cfg_err  (cfg_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R2 address map: slot = n below 3, n+1 from 3 upward
    function automatic logic [7:0] reg_addr(input int idx, input int fld);
        int slot;
        slot = (idx < 3) ? idx : idx + 1;
        return 8'(slot * 16 + fld * 4);
    endfunction

    // R4 control layout: 4 bits per channel at 4n
    function automatic logic [31:0] ctl(input int idx, input bit run, input bit slow, input bit ie);
        logic [31:0] v;
        v = {29'd0, ie, slow, run};
        return v << (4 * idx);
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
        addr = a;
        #0.5;
        chk(req, rd_data, exp);
    endtask

    task automatic tick_cycle(input bit e, input bit b);
        ext_tick = e; bus_tick = b;
        @(posedge clk);
        @(negedge clk);
        ext_tick = 1'b0; bus_tick = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; ext_tick = 0; bus_tick = 0; addr = 0; wr_en = 0; wr_data = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int i = 0; i < 8; i++) begin
            for (int f = 0; f < 4; f++) rd(reg_addr(i, f), 32'h0, "R1");
        end
        rd(8'h30, 32'h0, "R1");
        rd(8'h34, 32'h0, "R1");
        chk("R1", {24'd0, irq}, 32'h0);
        chk("R1", {31'd0, cfg_err}, 32'h0);

        // R2 map and readback, R8 count write while stopped
        for (int i = 0; i < 8; i++) begin
            wr(reg_addr(i, 1), 32'h1000 + i);
            wr(reg_addr(i, 2), 32'hA000 + i);
            wr(reg_addr(i, 3), 32'hB000 + i);
            wr(reg_addr(i, 0), 32'h5555);
        end
        for (int i = 0; i < 8; i++) begin
            rd(reg_addr(i, 1), 32'h1000 + i, "R2");
            rd(reg_addr(i, 2), 32'hA000 + i, "R2");
            rd(reg_addr(i, 3), 32'hB000 + i, "R2");
            rd(reg_addr(i, 0), 32'h0, "R8");
        end

        // R11 spare control word
        wr(8'h34, 32'hDEAD_BEEF);
        rd(8'h34, 32'hDEAD_BEEF, "R11");
        rd(8'h30, 32'h0, "R11");

        // R3 illegal offsets
        wr(8'h38, 32'hFFFF_FFFF);
        wr(8'h3C, 32'hFFFF_FFFF);
        wr(8'h90, 32'hFFFF_FFFF);
        wr(8'hF4, 32'hFFFF_FFFF);
        wr(8'h05, 32'hFFFF_FFFF);
        rd(8'h38, 32'h0, "R3");
        rd(8'h3C, 32'h0, "R3");
        rd(8'h90, 32'h0, "R3");
        rd(8'h05, 32'h0, "R3");
        for (int i = 0; i < 8; i++) rd(reg_addr(i, 1), 32'h1000 + i, "R3");
        rd(8'h30, 32'h0, "R3");
        rd(8'h34, 32'hDEAD_BEEF, "R3");

        // directed: channel 0, bus tick, interrupt on
        wr(reg_addr(0, 1), 32'd3);
        wr(8'h30, ctl(0, 1, 0, 1));
        tick_cycle(1, 0);
        rd(reg_addr(0, 0), 32'd0, "R4");
        tick_cycle(0, 1);
        rd(reg_addr(0, 0), 32'd3, "R6");
        chk("R6", {24'd0, irq}, 32'h01);
        tick_cycle(0, 0);
        chk("R6", {24'd0, irq}, 32'h00);
        tick_cycle(0, 1); rd(reg_addr(0, 0), 32'd2, "R5");
        tick_cycle(0, 1); rd(reg_addr(0, 0), 32'd1, "R5");
        tick_cycle(0, 1); rd(reg_addr(0, 0), 32'd0, "R5");
        chk("R6", {24'd0, irq}, 32'h00);
        tick_cycle(0, 1); rd(reg_addr(0, 0), 32'd3, "R6");
        chk("R6", {24'd0, irq}, 32'h01);

        wr(reg_addr(0, 0), 32'd10);
        rd(reg_addr(0, 0), 32'd10, "R8");
        wr(8'h30, 32'h0);
        rd(reg_addr(0, 0), 32'd3, "R7");
        wr(reg_addr(0, 1), 32'd7);
        rd(reg_addr(0, 0), 32'd3, "R9");
        wr(8'h30, 32'h0);
        rd(reg_addr(0, 0), 32'd3, "R7");
        wr(reg_addr(0, 0), 32'd9);
        rd(reg_addr(0, 0), 32'd3, "R8");

        // slow tick, interrupt off
        wr(8'h30, ctl(0, 1, 1, 0));
        tick_cycle(0, 1); rd(reg_addr(0, 0), 32'd3, "R4");
        tick_cycle(1, 0); tick_cycle(1, 1); tick_cycle(1, 0);
        rd(reg_addr(0, 0), 32'd0, "R5");
        tick_cycle(1, 0);
        rd(reg_addr(0, 0), 32'd7, "R9");
        chk("R6", {24'd0, irq}, 32'h00);
        wr(8'h30, 32'h0);
        rd(reg_addr(0, 0), 32'd7, "R7");

        // R10 waveform bits
        wr(8'h30, 32'h1 << 7);
        chk("R10", {31'd0, cfg_err}, 32'h1);
        rd(8'h30, 32'h0, "R10");
        wr(8'h30, 32'h1 << 23);
        chk("R10", {31'd0, cfg_err}, 32'h0);
        rd(8'h30, 32'h1 << 23, "R10");
        wr(8'h30, 32'h0);

        // random rounds against a bench model
        for (int r = 0; r < 16; r++) begin
            int idx, rel, cnt;
            bit slow, ie, e, b, sel, uf;
            idx  = $urandom % 8;
            rel  = $urandom % 6;
            slow = 1'($urandom % 2);
            ie   = 1'($urandom % 2);
            wr(reg_addr(idx, 1), 32'(rel));
            wr(8'h30, ctl(idx, 1, slow, ie));
            wr(reg_addr(idx, 0), 32'(rel));
            cnt = rel;
            rd(reg_addr(idx, 0), 32'(cnt), "R8");
            for (int c = 0; c < 30; c++) begin
                e = 1'($urandom % 2);
                b = 1'($urandom % 2);
                sel = slow ? e : b;
                uf = 1'b0;
                if (sel) begin
                    if (cnt == 0) begin cnt = rel; uf = 1'b1; end
                    else cnt = cnt - 1;
                end
                tick_cycle(e, b);
                rd(reg_addr(idx, 0), 32'(cnt), "R5");
                chk("R6", {24'd0, irq}, (uf && ie) ? (32'h1 << idx) : 32'h0);
            end
            wr(8'h30, 32'h0);
            rd(reg_addr(idx, 0), 32'(rel), "R7");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule